// File: doc/BRIEF.md
# Nibble-Wide BCD Calendar Clock

This block keeps time of day and calendar date as packed decimal digits, one digit per 4-bit register. A host reaches it over a small parallel bus: a 4-bit address, 4-bit write data, a write strobe, a read strobe and 4-bit read data. Thirteen registers hold the digits of the seconds, minutes, hours, day, month, year and weekday. Three control registers handle count freezing, a busy indication, an interrupt flag, a periodic interrupt rate and enables, 12/24-hour format, stop and reset.

The count advances on a one-pulse-per-second tick input. A second tick input at 64 pulses per second is the fastest source for the periodic interrupt. Each tick is a single-cycle pulse in the `clk` domain. The oscillator and prescaler that produce these ticks are outside the block.

Top module: `bcd_rtc`

## Requirements
- R1: After the synchronous reset, the time digits read 00:00:00, day 01, month 01, year 00 and weekday 0. Control D reads 0000, control E reads 0001 and control F reads 0100 (24-hour mode). Read data is registered: `bus_rdata` shows the register that was addressed while `bus_rd` was high, from the following cycle on.
- R2: Addresses 0 to 12 hold, in order, the seconds units and tens, minutes units and tens, hours units and tens, day units and tens, month units and tens, year units and tens, and the weekday. Address 13 is control D, 14 is control E and 15 is control F. A write to a time register stores all four bits.
- R3: When a 1 Hz tick is applied, the seconds advance with decimal carry: units 9 goes to 0 and carries into tens, and 59 goes to 00 and carries into the minutes. Minutes carry into the hours in the same way.
- R4: With control F bit 2 at 1 (24-hour mode), the hours run 00 to 23, and the step from 23 to 00 advances the day. With bit 2 at 0 (12-hour mode), hour-tens bit 2 is the PM flag and hour-tens bit 0 is the tens digit. In that mode the sequence is 11 AM, 12 PM, 01 PM, and the step from 11 PM to 12 AM advances the day.
- R5: A day advance steps the weekday from 6 back to 0. It wraps the day to 01 after the last day of the month: 30 for months 4, 6, 9 and 11, 31 for the other months, and for month 2 it is 29 when the year is a multiple of 4 and 28 otherwise. A wrap from month 12 goes to month 01 and advances the year, and year 99 wraps to 00.
- R6: While control D bit 0 (hold) is 1, ticks do not change the time; one pending advance is kept and applied once when hold returns to 0, however many ticks arrived. While control F bit 1 (stop) or bit 0 (reset) is 1, ticks are discarded.
- R7: Control D bit 1 (busy) reads 1 in the clock cycle right after an advance, and 0 otherwise.
- R8: While control F bit 0 (reset) is 1, both seconds digits stay at 0, even when they are written.
- R9: Writing control D with bit 3 set rounds the seconds to a whole minute. Seconds 30 to 59 become 00 and advance the minute; seconds 00 to 29 become 00 and leave the minute unchanged. Bit 3 always reads 0.
- R10: A write to control F whose bit 0 is 0, made while the stored bit 0 is 1, stores all four bits, including the new 12/24 mode in bit 2. Every other write to control F stores bits 3, 1 and 0 and leaves bit 2 unchanged.
- R11: Control E bits 3:2 select the periodic rate: 00 is each 64 Hz tick, 01 is each second advance, 10 is each minute carry and 11 is each hour carry. Bit 1 (STD) and bit 0 (MASK) must both be 0 for an event to set the interrupt flag, which is control D bit 2.
- R12: `irq` is high while the interrupt flag is set and control E arms the periodic interrupt. Writing control D with bit 2 at 0 clears the flag and drops `irq` on the next cycle. A control E write with STD or MASK at 1 drops `irq` on the next cycle.
- R13: When a periodic event and a flag-clearing write fall in the same cycle, the flag stays set. When a host write to a time register falls in the same cycle as an advance, the written digit takes the written value, and the other digits take their counted values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second that advances the count |
| tick_64hz | input | 1 | One-cycle pulse at 64 Hz, the fastest periodic-interrupt source |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 4 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data is returned the next cycle |
| bus_rdata | output | 4 | Registered read data |
| irq | output | 1 | Periodic interrupt output, active high |

## Verification
Two functions can act on the interrupt flag in the same cycle: setting it on a periodic event and clearing it from the host. The bench arms the 64 Hz rate and sets the flag. It then drives `tick_64hz` in the same cycle as a control D write with bit 2 at 0, and expects `irq` and the flag to stay high; a later clear, with no event in that cycle, must drop both. A second collision drives a seconds-units write in the same cycle as a 1 Hz tick. The written digit must win, while the seconds tens digit keeps its counted value.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

  localparam int DIG_W      = 4;
  localparam int ADDR_W     = 4;
  localparam int NUM_DIGITS = 13;
  localparam int BIN_W      = 7;
  localparam int RATE_N     = 4;

  typedef logic [DIG_W-1:0] digit_t;
  typedef logic [BIN_W-1:0] bin_t;

  // digit slots; the order is the host-visible address map
  localparam int IX_SEC_U = 0;
  localparam int IX_SEC_T = 1;
  localparam int IX_MIN_U = 2;
  localparam int IX_MIN_T = 3;
  localparam int IX_HR_U  = 4;
  localparam int IX_HR_T  = 5;
  localparam int IX_DAY_U = 6;
  localparam int IX_DAY_T = 7;
  localparam int IX_MON_U = 8;
  localparam int IX_MON_T = 9;
  localparam int IX_YR_U  = 10;
  localparam int IX_YR_T  = 11;
  localparam int IX_WDAY  = 12;

  localparam logic [ADDR_W-1:0] ADR_CTL_D = ADDR_W'(13);
  localparam logic [ADDR_W-1:0] ADR_CTL_E = ADDR_W'(14);
  localparam logic [ADDR_W-1:0] ADR_CTL_F = ADDR_W'(15);

  localparam digit_t CTL_E_INIT = 4'b0001;

  function automatic bin_t pair_to_bin(digit_t tens, digit_t units);
    return bin_t'(tens) * bin_t'(10) + bin_t'(units);
  endfunction

  function automatic logic [2*DIG_W-1:0] bin_to_pair(bin_t v);
    bin_t t;
    bin_t u;
    t = v / bin_t'(10);
    u = v % bin_t'(10);
    return {t[DIG_W-1:0], u[DIG_W-1:0]};
  endfunction

  function automatic bin_t days_in_month(bin_t mon, bin_t yr);
    case (mon)
      bin_t'(2):                           return (yr[1:0] == 2'b00) ? bin_t'(29) : bin_t'(28);
      bin_t'(4), bin_t'(6), bin_t'(9), bin_t'(11): return bin_t'(30);
      default:                             return bin_t'(31);
    endcase
  endfunction

  // 12-hour digits (tens bit2 = PM, tens bit0 = tens digit) to 0..23
  function automatic bin_t hour12_to_24(digit_t tens, digit_t units);
    bin_t h12;
    bin_t base;
    h12  = pair_to_bin({3'b000, tens[0]}, units);
    base = (h12 == bin_t'(12)) ? bin_t'(0) : h12;
    return base + (tens[2] ? bin_t'(12) : bin_t'(0));
  endfunction

  function automatic logic [2*DIG_W-1:0] hour24_to_12(bin_t h);
    logic pm;
    bin_t r;
    logic [2*DIG_W-1:0] p;
    pm = (h >= bin_t'(12));
    r  = pm ? h - bin_t'(12) : h;
    if (r == bin_t'(0)) r = bin_t'(12);
    p  = bin_to_pair(r);
    return {1'b0, pm, 1'b0, p[DIG_W], p[DIG_W-1:0]};
  endfunction

endpackage

// File: rtl/bcd_rtc_timekeep.sv
module bcd_rtc_timekeep
  import bcd_rtc_pkg::*;
#(
  parameter int NDIG = NUM_DIGITS,
  parameter int AW   = ADDR_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        advance,
  input  logic                        adjust,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_addr,
  input  digit_t                      wr_data,
  input  logic                        mode24,
  input  logic                        sec_clear,
  output logic [NDIG-1:0][DIG_W-1:0]  digits,
  output logic                        min_carry,
  output logic                        hour_carry
);

  bin_t   sec, mnt, hr, day, mon, yr;
  digit_t wday;
  logic   c_min, c_hr, c_day, c_mon;
  logic [NDIG-1:0][DIG_W-1:0] nxt;

  always_comb begin
    sec  = pair_to_bin(digits[IX_SEC_T], digits[IX_SEC_U]);
    mnt  = pair_to_bin(digits[IX_MIN_T], digits[IX_MIN_U]);
    hr   = mode24 ? pair_to_bin(digits[IX_HR_T], digits[IX_HR_U])
                  : hour12_to_24(digits[IX_HR_T], digits[IX_HR_U]);
    day  = pair_to_bin(digits[IX_DAY_T], digits[IX_DAY_U]);
    mon  = pair_to_bin(digits[IX_MON_T], digits[IX_MON_U]);
    yr   = pair_to_bin(digits[IX_YR_T], digits[IX_YR_U]);
    wday = digits[IX_WDAY];
    c_min = 1'b0;
    c_hr  = 1'b0;
    c_day = 1'b0;
    c_mon = 1'b0;

    if (adjust) begin
      c_min = (sec >= bin_t'(30));
      sec   = '0;
    end else if (advance) begin
      if (sec >= bin_t'(59)) begin
        sec   = '0;
        c_min = 1'b1;
      end else sec = sec + bin_t'(1);
    end

    if (c_min) begin
      if (mnt >= bin_t'(59)) begin
        mnt  = '0;
        c_hr = 1'b1;
      end else mnt = mnt + bin_t'(1);
    end

    if (c_hr) begin
      if (hr >= bin_t'(23)) begin
        hr    = '0;
        c_day = 1'b1;
      end else hr = hr + bin_t'(1);
    end

    if (c_day) begin
      wday = (wday >= digit_t'(6)) ? digit_t'(0) : wday + digit_t'(1);
      if (day >= days_in_month(mon, yr)) begin
        day   = bin_t'(1);
        c_mon = 1'b1;
      end else day = day + bin_t'(1);
    end

    if (c_mon) begin
      if (mon >= bin_t'(12)) begin
        mon = bin_t'(1);
        yr  = (yr >= bin_t'(99)) ? bin_t'(0) : yr + bin_t'(1);
      end else mon = mon + bin_t'(1);
    end

    nxt = digits;
    {nxt[IX_SEC_T], nxt[IX_SEC_U]} = bin_to_pair(sec);
    {nxt[IX_MIN_T], nxt[IX_MIN_U]} = bin_to_pair(mnt);
    {nxt[IX_HR_T],  nxt[IX_HR_U]}  = mode24 ? bin_to_pair(hr) : hour24_to_12(hr);
    {nxt[IX_DAY_T], nxt[IX_DAY_U]} = bin_to_pair(day);
    {nxt[IX_MON_T], nxt[IX_MON_U]} = bin_to_pair(mon);
    {nxt[IX_YR_T],  nxt[IX_YR_U]}  = bin_to_pair(yr);
    nxt[IX_WDAY] = wday;

    // host write takes the digit it addresses, even during an advance
    if (wr_en && (wr_addr < AW'(NDIG))) nxt[wr_addr] = wr_data;

    if (sec_clear) begin
      nxt[IX_SEC_U] = '0;
      nxt[IX_SEC_T] = '0;
    end
  end

  assign min_carry  = c_min;
  assign hour_carry = c_hr;

  always_ff @(posedge clk) begin
    if (rst) begin
      digits           <= '0;
      digits[IX_DAY_U] <= digit_t'(1);
      digits[IX_MON_U] <= digit_t'(1);
    end else begin
      digits <= nxt;
    end
  end

endmodule

// File: rtl/bcd_rtc_periodic.sv
module bcd_rtc_periodic
  import bcd_rtc_pkg::*;
#(
  parameter int NSRC   = RATE_N,
  localparam int SEL_W = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] events,
  input  logic            cfg_wr,
  input  digit_t          cfg_data,
  input  logic            flag_clr,
  output digit_t          cfg,
  output logic            flag,
  output logic            irq
);

  logic   armed, hit, flag_nxt;
  digit_t cfg_nxt;

  always_comb begin
    armed    = (cfg[1:0] == 2'b00);
    hit      = armed && events[cfg[DIG_W-1 -: SEL_W]];
    cfg_nxt  = cfg_wr ? cfg_data : cfg;
    // a new event beats a host clear in the same cycle
    flag_nxt = hit ? 1'b1 : (flag_clr ? 1'b0 : flag);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg  <= CTL_E_INIT;
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      cfg  <= cfg_nxt;
      flag <= flag_nxt;
      irq  <= flag_nxt && (cfg_nxt[1:0] == 2'b00);
    end
  end

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import bcd_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              tick_64hz,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DIG_W-1:0]  bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DIG_W-1:0]  bus_rdata,
  output logic              irq
);

  logic wr_d, wr_e, wr_f, is_digit;
  logic hold_q, busy_q, pend_q;
  logic test_q, mode24_q, stop_q, rstb_q;
  logic adv, adj;
  logic min_carry, hour_carry, flag;
  digit_t cfg_e;
  logic [NUM_DIGITS-1:0][DIG_W-1:0] digits;

  assign wr_d     = bus_wr && (bus_addr == ADR_CTL_D);
  assign wr_e     = bus_wr && (bus_addr == ADR_CTL_E);
  assign wr_f     = bus_wr && (bus_addr == ADR_CTL_F);
  assign is_digit = bus_addr < ADDR_W'(NUM_DIGITS);
  assign adj      = wr_d && bus_wdata[3];
  assign adv      = !hold_q && !stop_q && !rstb_q && (tick_1hz || pend_q);

  bcd_rtc_timekeep #(.NDIG(NUM_DIGITS), .AW(ADDR_W)) u_time (
    .clk        (clk),
    .rst        (rst),
    .advance    (adv),
    .adjust     (adj),
    .wr_en      (bus_wr),
    .wr_addr    (bus_addr),
    .wr_data    (bus_wdata),
    .mode24     (mode24_q),
    .sec_clear  (rstb_q),
    .digits     (digits),
    .min_carry  (min_carry),
    .hour_carry (hour_carry)
  );

  bcd_rtc_periodic #(.NSRC(RATE_N)) u_periodic (
    .clk      (clk),
    .rst      (rst),
    .events   ({hour_carry, min_carry, adv, tick_64hz}),
    .cfg_wr   (wr_e),
    .cfg_data (bus_wdata),
    .flag_clr (wr_d && !bus_wdata[2]),
    .cfg      (cfg_e),
    .flag     (flag),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= 1'b0;
      busy_q   <= 1'b0;
      pend_q   <= 1'b0;
      test_q   <= 1'b0;
      mode24_q <= 1'b1;
      stop_q   <= 1'b0;
      rstb_q   <= 1'b0;
    end else begin
      busy_q <= adv;
      pend_q <= hold_q && (pend_q || tick_1hz);
      if (wr_d) hold_q <= bus_wdata[0];
      if (wr_f) begin
        test_q <= bus_wdata[3];
        stop_q <= bus_wdata[1];
        rstb_q <= bus_wdata[0];
        if (rstb_q && !bus_wdata[0]) mode24_q <= bus_wdata[2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (is_digit)                     bus_rdata <= digits[bus_addr];
      else if (bus_addr == ADR_CTL_D)   bus_rdata <= {1'b0, flag, busy_q, hold_q};
      else if (bus_addr == ADR_CTL_E)   bus_rdata <= cfg_e;
      else                              bus_rdata <= {test_q, mode24_q, stop_q, rstb_q};
    end
  end

endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk
  import bcd_rtc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              tick_1hz,
  input logic              tick_64hz,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DIG_W-1:0]  bus_wdata,
  input logic              bus_wr,
  input logic              irq,
  input logic              hold_q,
  input logic              stop_q,
  input logic              rstb_q,
  input logic              busy_q,
  input logic              mode24_q,
  input logic              flag,
  input logic [DIG_W-1:0]  cfg_e,
  input logic [DIG_W-1:0]  sec_u,
  input logic [DIG_W-1:0]  sec_t
);

  p_busy_after_tick_r7: assert property (@(posedge clk) disable iff (rst)
    (tick_1hz && !hold_q && !stop_q && !rstb_q) |=> busy_q);

  p_stop_freezes_r6: assert property (@(posedge clk) disable iff (rst)
    (stop_q && !bus_wr) |=> $stable(sec_u) && $stable(sec_t));

  p_sec_zero_r8: assert property (@(posedge clk) disable iff (rst)
    rstb_q |=> (sec_u == '0) && (sec_t == '0));

  p_mode_locked_r10: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && (bus_addr == ADR_CTL_F) && !bus_wdata[0] && rstb_q) |=> $stable(mode24_q));

  p_disarm_drops_irq_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr == ADR_CTL_E) && (bus_wdata[1:0] != 2'b00)) |=> !irq);

  p_event_beats_clear_r13: assert property (@(posedge clk) disable iff (rst)
    (tick_64hz && (cfg_e == 4'b0000)) |=> flag);

endmodule

bind bcd_rtc bcd_rtc_chk u_bcd_rtc_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_1hz  (tick_1hz),
  .tick_64hz (tick_64hz),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .irq       (irq),
  .hold_q    (hold_q),
  .stop_q    (stop_q),
  .rstb_q    (rstb_q),
  .busy_q    (busy_q),
  .mode24_q  (mode24_q),
  .flag      (flag),
  .cfg_e     (cfg_e),
  .sec_u     (digits[0]),
  .sec_t     (digits[1])
);

// File: tb/bcd_rtc_bench.sv
module bcd_rtc_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_1hz = 1'b0;
  logic       tick_64hz = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [3:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [3:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bcd_rtc u_bcd_rtc (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .tick_64hz(tick_64hz),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [51:0] got, input logic [51:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [3:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic tick(); @(negedge clk); tick_1hz = 1'b1; @(negedge clk); tick_1hz = 1'b0; endtask
  task automatic tick64(); @(negedge clk); tick_64hz = 1'b1; @(negedge clk); tick_64hz = 1'b0; endtask

  // digits packed as {wday, yr, mon, day, hr, min, sec}, units in the low nibble
  task automatic set_all(input logic [51:0] v);
    for (int i = 0; i < 13; i++) wr(4'(i), v[4*i +: 4]);
  endtask

  task automatic read_all(output logic [51:0] v);
    logic [3:0] d;
    for (int i = 0; i < 13; i++) begin
      rd(4'(i), d);
      v[4*i +: 4] = d;
    end
  endtask

  task automatic rd_check(input string tag, input logic [3:0] a, input logic [3:0] exp);
    logic [3:0] d;
    rd(a, d);
    check(tag, 52'(d), 52'(exp));
  endtask

  task automatic step_check(input string tag, input logic [51:0] start, input logic [51:0] exp);
    logic [51:0] v;
    set_all(start);
    tick();
    read_all(v);
    check(tag, v, exp);
  endtask

  task automatic t_reset();
    logic [51:0] v;
    read_all(v);
    check("R1 reset time digits", v, 52'h0_00_01_01_00_00_00);
    rd_check("R1 reset ctl D", 4'd13, 4'b0000);
    rd_check("R1 reset ctl E", 4'd14, 4'b0001);
    rd_check("R1 reset ctl F", 4'd15, 4'b0100);
    check("R12 irq low after reset", 52'(irq), 52'd0);
  endtask

  task automatic t_regs();
    wr(4'd3, 4'h5);
    rd_check("R2 minute tens write/read", 4'd3, 4'h5);
    wr(4'd12, 4'h3);
    rd_check("R2 weekday write/read", 4'd12, 4'h3);
  endtask

  task automatic t_count24();
    step_check("R3 seconds units", 52'h2_24_05_10_08_14_37, 52'h2_24_05_10_08_14_38);
    step_check("R3 seconds tens carry", 52'h2_24_05_10_08_14_39, 52'h2_24_05_10_08_14_40);
    step_check("R3 minute carry", 52'h2_24_05_10_08_19_59, 52'h2_24_05_10_08_20_00);
    step_check("R4 R5 full rollover", 52'h6_99_12_31_23_59_59, 52'h0_00_01_01_00_00_00);
    step_check("R5 leap February", 52'h3_24_02_28_23_59_59, 52'h4_24_02_29_00_00_00);
    step_check("R5 plain February", 52'h3_23_02_28_23_59_59, 52'h4_23_03_01_00_00_00);
    step_check("R5 thirty-day month", 52'h5_23_04_30_23_59_59, 52'h6_23_05_01_00_00_00);
  endtask

  task automatic t_mode_reset();
    logic [3:0] d;
    wr(4'd15, 4'b0001);
    rd_check("R10 mode kept on set of reset", 4'd15, 4'b0101);
    wr(4'd0, 4'h7);
    rd_check("R8 seconds held at zero", 4'd0, 4'h0);
    tick();
    rd_check("R6 tick discarded in reset", 4'd0, 4'h0);
    wr(4'd15, 4'b0000);
    rd_check("R10 mode set on reset release", 4'd15, 4'b0000);
    step_check("R4 11PM to 12AM", 52'h1_23_06_15_51_59_59, 52'h2_23_06_16_12_00_00);
    step_check("R4 11AM to 12PM", 52'h1_23_06_15_11_59_59, 52'h1_23_06_15_52_00_00);
    step_check("R4 12PM to 1PM", 52'h1_23_06_15_52_59_59, 52'h1_23_06_15_41_00_00);
    wr(4'd15, 4'b0100);
    rd_check("R10 mode locked outside release", 4'd15, 4'b0000);
    wr(4'd15, 4'b0001);
    wr(4'd15, 4'b0100);
    rd(4'd15, d);
    check("R10 back to 24-hour", 52'(d), 52'(4'b0100));
  endtask

  task automatic t_hold_busy_stop();
    set_all(52'h0_00_01_01_00_00_10);
    wr(4'd13, 4'b0001);
    tick();
    tick();
    rd_check("R6 hold freezes count", 4'd0, 4'h0);
    rd_check("R6 hold bit reads back", 4'd13, 4'b0001);
    wr(4'd13, 4'b0000);
    rd_check("R6 one pending advance applied", 4'd0, 4'h1);
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0; bus_addr = 4'd13; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    check("R7 busy after advance", 52'(bus_rdata), 52'(4'b0010));
    rd_check("R7 busy drops", 4'd13, 4'b0000);
    wr(4'd15, 4'b0010);
    tick();
    rd_check("R6 stop discards tick", 4'd0, 4'h2);
    wr(4'd15, 4'b0000);
    rd_check("R6 stop released", 4'd15, 4'b0100);
  endtask

  task automatic t_adjust();
    logic [51:0] v;
    set_all(52'h0_00_01_01_00_10_45);
    wr(4'd13, 4'b1000);
    read_all(v);
    check("R9 round up", v, 52'h0_00_01_01_00_11_00);
    rd_check("R9 adjust bit self-clears", 4'd13, 4'b0000);
    set_all(52'h0_00_01_01_00_10_29);
    wr(4'd13, 4'b1000);
    read_all(v);
    check("R9 round down", v, 52'h0_00_01_01_00_10_00);
    set_all(52'h0_00_01_01_05_59_30);
    wr(4'd13, 4'b1000);
    read_all(v);
    check("R9 round up with hour carry", v, 52'h0_00_01_01_06_00_00);
  endtask

  task automatic t_periodic();
    wr(4'd14, 4'b0000);
    check("R11 armed but no event", 52'(irq), 52'd0);
    tick64();
    check("R11 64 Hz sets irq", 52'(irq), 52'd1);
    rd_check("R11 flag bit set", 4'd13, 4'b0100);
    wr(4'd13, 4'b0000);
    check("R12 clear drops irq", 52'(irq), 52'd0);
    rd_check("R12 flag cleared", 4'd13, 4'b0000);
    tick64();
    wr(4'd14, 4'b0010);
    check("R12 STD disarms irq", 52'(irq), 52'd0);
    rd_check("R11 ctl E stores all bits", 4'd14, 4'b0010);
    wr(4'd13, 4'b0000);
    wr(4'd14, 4'b0100);
    tick64();
    check("R11 1 s rate ignores 64 Hz", 52'(irq), 52'd0);
    tick();
    check("R11 1 s rate fires", 52'(irq), 52'd1);
    wr(4'd13, 4'b0000);
    wr(4'd14, 4'b1000);
    set_all(52'h0_00_01_01_05_10_58);
    tick();
    check("R11 minute rate quiet at :59", 52'(irq), 52'd0);
    tick();
    check("R11 minute rate fires", 52'(irq), 52'd1);
    wr(4'd13, 4'b0000);
    wr(4'd14, 4'b1100);
    set_all(52'h0_00_01_01_05_59_59);
    tick();
    check("R11 hour rate fires", 52'(irq), 52'd1);
    wr(4'd13, 4'b0000);
  endtask

  task automatic t_collide();
    logic [51:0] v;
    wr(4'd14, 4'b0000);
    tick64();
    @(negedge clk); bus_addr = 4'd13; bus_wdata = 4'b0000; bus_wr = 1'b1; tick_64hz = 1'b1;
    @(negedge clk); bus_wr = 1'b0; tick_64hz = 1'b0;
    check("R13 event beats clear (irq)", 52'(irq), 52'd1);
    rd_check("R13 event beats clear (flag)", 4'd13, 4'b0100);
    wr(4'd13, 4'b0000);
    check("R13 later clear drops irq", 52'(irq), 52'd0);
    wr(4'd14, 4'b0001);
    set_all(52'h0_00_01_01_05_20_05);
    @(negedge clk); bus_addr = 4'd0; bus_wdata = 4'h8; bus_wr = 1'b1; tick_1hz = 1'b1;
    @(negedge clk); bus_wr = 1'b0; tick_1hz = 1'b0;
    read_all(v);
    check("R13 write wins over advance", v, 52'h0_00_01_01_05_20_08);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_count24();
    t_mode_reset();
    t_hold_busy_stop();
    t_adjust();
    t_periodic();
    t_collide();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule